// File: doc/BRIEF.md
# Serial EEPROM Image Cache and Checksum Engine

This block sits between a host and a serial EEPROM master. It keeps a local shadow of a 64-word, 16-bit configuration image. Host accesses to cached data are served from the shadow while a signature field held in the shadow is valid. When the signature is not valid, the block first reloads every word through the master and then judges the image. The image is accepted only when the 16-bit sum of all words is 0xBABA and the signature field carries its valid code.

The host can ask for a single cached word, for a 48-bit station address built from three words, or for a 32-bit board number built from two words. It can also force a reload, forward a word write to the EEPROM, or ask the block to recompute and store the checksum word. Any write spoils the cached signature, so the next cached access reloads the image.

Each command is a single-cycle request taken while the block is idle. The block raises `busy` until the command ends. The command ends with a one-cycle `done` pulse that carries the status and the result.

Top module: `eil_image_loader`

## Requirements
- R1: After reset, `busy`, `done` and `mst_req` are low and the shadow signature is invalid, so the first cached access performs a full reload.
- R2: A reload reads words 0 to 63 in ascending order through the master, one read for each acknowledged request. While `mst_req` is high and `mst_ack` is low, the request, address, write flag and write data hold steady.
- R3: After a reload the image is valid only when the modulo-2^16 sum of all 64 words equals 0xBABA and (word 10 & 0xC000) == 0x4000.
- R4: When the reload sum differs from 0xBABA, the cached word 10 is replaced by 0x0000. Every later cached access therefore reloads again.
- R5: A cached access (word, station or board) made while the signature is valid causes no master traffic. Its `done` comes in the second cycle after the accepting edge.
- R6: A word read (op 0) with an index of 64 or more returns 0 with status 0 and no master traffic. A word read that still finds the image invalid after its reload also returns 0 with status 0. In every case, a status of 0 comes with a result of 0.
- R7: A station read (op 1) returns resp_data = {word2, word1, word0}, so the low byte of word 0 is the first address byte. A board read (op 2) returns {word9, word8} in bits 31:0 with bits 47:32 zero.
- R8: A write (op 4) with an index below 64 forwards exactly one master write of `cmd_wdata` to that index, sets cached word 10 to 0x0000 and reports status 1. With an index of 64 or more it makes no transfer, leaves the cache unchanged and reports status 0.
- R9: An update (op 5) reads words 0 to 62, writes 0xBABA minus their sum to word 63, clears the cached signature and reports status 1.
- R10: A load (op 3) always reloads, even when the image is valid, and reports the resulting validity with a result of 0.
- R11: `busy` rises in the cycle after a command is accepted and stays high through the single `done` cycle. `cmd_valid` has no effect while `busy` is high.
- R12: Opcodes 6 and 7 complete with status 0 and result 0, with no master traffic and no change to the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 3 | Command code: 0 word, 1 station, 2 board, 3 load, 4 write, 5 update |
| cmd_idx | input | 7 | Word index for word read and write |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Completion status, valid with done |
| resp_data | output | 48 | Result, valid with done |
| mst_req | output | 1 | Transfer request to the EEPROM master |
| mst_we | output | 1 | Transfer is a write |
| mst_addr | output | 6 | EEPROM word address |
| mst_wdata | output | 16 | Write data to the master |
| mst_ack | input | 1 | One-cycle completion from the master |
| mst_rdata | input | 16 | Read data, valid with mst_ack |

## Verification
The assertions take three things for granted about the inputs. First, the master raises `mst_ack` only while `mst_req` is high, for one cycle for each transfer. Second, the host offers commands only once the internal reset synchronizer has released. Third, the master answers every request in bounded time. The bench meets these conditions with a behavioural master that acknowledges each request after a fixed wait and drops the acknowledge the following cycle. It also waits several cycles after reset before the first command, and it deliberately raises `cmd_valid` only in the middle of a busy command, to test that the request is ignored.

// File: rtl/eil_pkg.sv
package eil_pkg;
  typedef enum logic [2:0] {
    OP_WORD    = 3'd0,
    OP_STATION = 3'd1,
    OP_BOARD   = 3'd2,
    OP_LOAD    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_UPDATE  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_RD,
    S_EVAL,
    S_WR,
    S_DONE
  } state_e;
endpackage

// File: rtl/eil_shadow.sv
module eil_shadow #(
  parameter int DW       = 16,
  parameter int DEPTH    = 64,
  parameter int AW       = 6,
  parameter int SIG_IDX  = 10,
  parameter int ST_IDX   = 0,
  parameter int ST_WORDS = 3,
  parameter int BD_IDX   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [DW-1:0]          sig_word,
  output logic [ST_WORDS*DW-1:0] station,
  output logic [2*DW-1:0]        board
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data  = mem_q[rd_addr];
  assign sig_word = mem_q[SIG_IDX];
  assign board    = {mem_q[BD_IDX+1], mem_q[BD_IDX]};

  for (genvar g = 0; g < ST_WORDS; g++) begin : g_station
    assign station[g*DW +: DW] = mem_q[ST_IDX+g];
  end
endmodule

// File: rtl/eil_sum_acc.sv
module eil_sum_acc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] add_val,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] sum_q, sum_d;
  logic          sum_en;

  always_comb begin
    sum_en = clr | add_en;
    sum_d  = clr ? '0 : sum_q + add_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/eil_ctl.sv
module eil_ctl
  import eil_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          DEPTH     = 64,
  parameter int          AW        = 6,
  parameter int          IW        = 7,
  parameter int          RW        = 48,
  parameter int          SIG_IDX   = 10,
  parameter logic [15:0] SIG_MASK  = 16'hC000,
  parameter logic [15:0] SIG_VALID = 16'h4000,
  parameter logic [15:0] SIG_CLEAR = 16'h0000,
  parameter logic [15:0] SUM_GOAL  = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic          done_ok,
  output logic [RW-1:0] resp_data,
  output logic          mst_req,
  output logic          mst_we,
  output logic [AW-1:0] mst_addr,
  output logic [DW-1:0] mst_wdata,
  input  logic          mst_ack,
  input  logic [DW-1:0] mst_rdata,
  input  logic [DW-1:0] sig_word,
  input  logic [DW-1:0] sel_word,
  input  logic [RW-1:0] station,
  input  logic [2*DW-1:0] board,
  input  logic [DW-1:0] sum,
  output logic [AW-1:0] rd_addr,
  output logic          shd_we,
  output logic [AW-1:0] shd_addr,
  output logic [DW-1:0] shd_wdata,
  output logic          acc_clr,
  output logic          acc_add
);
  localparam logic [AW-1:0] LAST_ALL = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_UPD = AW'(DEPTH - 2);
  localparam logic [AW-1:0] SIG_A    = AW'(SIG_IDX);
  localparam logic [IW-1:0] IDX_LIM  = IW'(DEPTH);

  state_e        state_q, state_n;
  op_e           op_q, op_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic [AW-1:0] cnt_q, cnt_n;
  logic          loaded_q, loaded_n;
  logic          ok_q, ok_n;
  logic [RW-1:0] resp_q, resp_n;

  logic sig_ok, in_range, last_rd, is_upd;

  always_comb begin
    sig_ok   = (sig_word & SIG_MASK) == SIG_VALID;
    in_range = idx_q < IDX_LIM;
    is_upd   = op_q == OP_UPDATE;
    last_rd  = cnt_q == (is_upd ? LAST_UPD : LAST_ALL);
  end

  always_comb begin
    state_n   = state_q;
    op_n      = op_q;
    idx_n     = idx_q;
    wdata_n   = wdata_q;
    cnt_n     = cnt_q;
    loaded_n  = loaded_q;
    ok_n      = ok_q;
    resp_n    = resp_q;
    mst_req   = 1'b0;
    mst_we    = 1'b0;
    mst_addr  = cnt_q;
    mst_wdata = '0;
    shd_we    = 1'b0;
    shd_addr  = cnt_q;
    shd_wdata = mst_rdata;
    acc_clr   = 1'b0;
    acc_add   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          op_n     = op_e'(cmd_op);
          idx_n    = cmd_idx;
          wdata_n  = cmd_wdata;
          loaded_n = 1'b0;
          state_n  = S_CHK;
        end
      end
      S_CHK: begin
        ok_n    = 1'b0;
        resp_n  = '0;
        state_n = S_DONE;
        unique case (op_q)
          OP_WORD, OP_STATION, OP_BOARD: begin
            if (op_q == OP_WORD && !in_range) begin
              state_n = S_DONE;
            end else if (sig_ok) begin
              ok_n = 1'b1;
              if (op_q == OP_WORD)         resp_n = RW'(sel_word);
              else if (op_q == OP_STATION) resp_n = station;
              else                         resp_n = RW'(board);
            end else if (!loaded_q) begin
              cnt_n   = '0;
              acc_clr = 1'b1;
              state_n = S_RD;
            end
          end
          OP_LOAD: begin
            if (loaded_q) begin
              ok_n = sig_ok;
            end else begin
              cnt_n   = '0;
              acc_clr = 1'b1;
              state_n = S_RD;
            end
          end
          OP_WRITE: begin
            if (in_range) state_n = S_WR;
          end
          OP_UPDATE: begin
            cnt_n   = '0;
            acc_clr = 1'b1;
            state_n = S_RD;
          end
          default: state_n = S_DONE;
        endcase
      end
      S_RD: begin
        mst_req = 1'b1;
        if (mst_ack) begin
          acc_add = 1'b1;
          shd_we  = !is_upd;
          if (last_rd) state_n = is_upd ? S_WR : S_EVAL;
          else         cnt_n   = cnt_q + 1'b1;
        end
      end
      S_EVAL: begin
        if (sum != SUM_GOAL) begin
          shd_we    = 1'b1;
          shd_addr  = SIG_A;
          shd_wdata = SIG_CLEAR;
        end
        loaded_n = 1'b1;
        state_n  = S_CHK;
      end
      S_WR: begin
        mst_req   = 1'b1;
        mst_we    = 1'b1;
        mst_addr  = is_upd ? LAST_ALL : idx_q[AW-1:0];
        mst_wdata = is_upd ? (SUM_GOAL - sum) : wdata_q;
        if (mst_ack) begin
          shd_we    = 1'b1;
          shd_addr  = SIG_A;
          shd_wdata = SIG_CLEAR;
          ok_n      = 1'b1;
          resp_n    = '0;
          state_n   = S_DONE;
        end
      end
      S_DONE: state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_WORD;
      idx_q    <= '0;
      wdata_q  <= '0;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      ok_q     <= 1'b0;
      resp_q   <= '0;
    end else begin
      state_q  <= state_n;
      op_q     <= op_n;
      idx_q    <= idx_n;
      wdata_q  <= wdata_n;
      cnt_q    <= cnt_n;
      loaded_q <= loaded_n;
      ok_q     <= ok_n;
      resp_q   <= resp_n;
    end
  end

  assign busy      = state_q != S_IDLE;
  assign done      = state_q == S_DONE;
  assign done_ok   = ok_q;
  assign resp_data = resp_q;
  assign rd_addr   = idx_q[AW-1:0];
endmodule

// File: rtl/eil_image_loader.sv
module eil_image_loader #(
  parameter int          DW        = 16,
  parameter int          DEPTH     = 64,
  parameter int          SIG_IDX   = 10,
  parameter logic [15:0] SIG_MASK  = 16'hC000,
  parameter logic [15:0] SIG_VALID = 16'h4000,
  parameter logic [15:0] SIG_CLEAR = 16'h0000,
  parameter logic [15:0] SUM_GOAL  = 16'hBABA,
  parameter int          ST_IDX    = 0,
  parameter int          BD_IDX    = 8,
  parameter int          AW        = $clog2(DEPTH),
  parameter int          IW        = AW + 1,
  parameter int          RW        = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic          done_ok,
  output logic [RW-1:0] resp_data,
  output logic          mst_req,
  output logic          mst_we,
  output logic [AW-1:0] mst_addr,
  output logic [DW-1:0] mst_wdata,
  input  logic          mst_ack,
  input  logic [DW-1:0] mst_rdata
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [DW-1:0]   sig_word, sel_word, sum;
  logic [RW-1:0]   station;
  logic [2*DW-1:0] board;
  logic [AW-1:0]   rd_addr, shd_addr;
  logic [DW-1:0]   shd_wdata;
  logic            shd_we, acc_clr, acc_add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eil_shadow #(
    .DW(DW), .DEPTH(DEPTH), .AW(AW), .SIG_IDX(SIG_IDX),
    .ST_IDX(ST_IDX), .ST_WORDS(3), .BD_IDX(BD_IDX)
  ) u_shadow (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(shd_we), .wr_addr(shd_addr), .wr_data(shd_wdata),
    .rd_addr(rd_addr), .rd_data(sel_word), .sig_word(sig_word),
    .station(station), .board(board)
  );

  eil_sum_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .clr(acc_clr), .add_en(acc_add),
    .add_val(mst_rdata), .sum(sum)
  );

  eil_ctl #(
    .DW(DW), .DEPTH(DEPTH), .AW(AW), .IW(IW), .RW(RW), .SIG_IDX(SIG_IDX),
    .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID), .SIG_CLEAR(SIG_CLEAR),
    .SUM_GOAL(SUM_GOAL)
  ) u_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .done_ok(done_ok), .resp_data(resp_data),
    .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_ack(mst_ack), .mst_rdata(mst_rdata),
    .sig_word(sig_word), .sel_word(sel_word), .station(station), .board(board),
    .sum(sum), .rd_addr(rd_addr), .shd_we(shd_we), .shd_addr(shd_addr),
    .shd_wdata(shd_wdata), .acc_clr(acc_clr), .acc_add(acc_add)
  );
endmodule

// File: rtl/eil_image_loader_chk.sv
module eil_image_loader_chk #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int RW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          done_ok,
  input logic [RW-1:0] resp_data,
  input logic          mst_req,
  input logic          mst_we,
  input logic [AW-1:0] mst_addr,
  input logic [DW-1:0] mst_wdata,
  input logic          mst_ack
);
  a_r11_done_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_valid |=> !busy);

  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid |=> busy);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req && !mst_ack |=> mst_req && $stable(mst_addr) && $stable(mst_we) && $stable(mst_wdata));

  a_r1_req_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req |-> busy && !done);

  a_r6_zero_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok |-> resp_data == '0);

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |-> mst_req);
endmodule

bind eil_image_loader eil_image_loader_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .done_ok(done_ok), .resp_data(resp_data), .mst_req(mst_req), .mst_we(mst_we),
  .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_ack(mst_ack)
);

// File: tb/eil_image_loader_bench.sv
module eil_image_loader_bench;
  localparam int LAT = 3;

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [6:0]  cmd_idx;
  logic [15:0] cmd_wdata;
  logic        busy, done, done_ok;
  logic [47:0] resp_data;
  logic        mst_req, mst_we, mst_ack;
  logic [5:0]  mst_addr;
  logic [15:0] mst_wdata, mst_rdata;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  logic [15:0] ee      [64];
  logic [15:0] mdl_ee  [64];
  logic [15:0] mdl_c   [64];
  logic [22:0] exp_q   [$];

  eil_image_loader u_eil_image_loader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .done_ok(done_ok), .resp_data(resp_data), .mst_req(mst_req), .mst_we(mst_we),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_ack(mst_ack), .mst_rdata(mst_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
        summary();
      end
    end
  end

  // behavioural master: acknowledge after LAT cycles, checks the expected transfer order
  initial begin
    int lat;
    lat = 0;
    mst_ack = 1'b0;
    mst_rdata = '0;
    forever begin
      @(negedge clk);
      if (mst_ack) begin
        mst_ack = 1'b0;
        lat = 0;
      end else if (mst_req) begin
        lat++;
        if (lat == LAT) begin
          logic [22:0] e;
          lat = 0;
          mst_ack = 1'b1;
          mst_rdata = ee[mst_addr];
          if (exp_q.size() == 0) begin
            chk("R2 unexpected transfer", {41'd0, mst_we, mst_addr}, 48'hFFFF);
          end else begin
            e = exp_q.pop_front();
            chk("R2 transfer kind/address", {41'd0, mst_we, mst_addr}, {41'd0, e[22:16]});
            if (e[22]) chk("R8 R9 write data", {32'd0, mst_wdata}, {32'd0, e[15:0]});
          end
          if (mst_we) ee[mst_addr] = mst_wdata;
        end
      end else begin
        lat = 0;
      end
    end
  end

  function automatic logic mdl_sig_ok();
    return (mdl_c[10] & 16'hC000) == 16'h4000;
  endfunction

  task automatic mdl_reload();
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 64; i++) begin
      exp_q.push_back({1'b0, 6'(i), 16'h0});
      mdl_c[i] = mdl_ee[i];
      s += mdl_ee[i];
    end
    if (s != 16'hBABA) mdl_c[10] = 16'h0000;
  endtask

  task automatic predict(input int op, input int idx, input logic [15:0] wd,
                         output logic ok, output logic [47:0] data);
    ok = 1'b0;
    data = '0;
    case (op)
      0, 1, 2: begin
        if (op == 0 && idx >= 64) return;
        if (!mdl_sig_ok()) mdl_reload();
        if (!mdl_sig_ok()) return;
        ok = 1'b1;
        if (op == 0)      data = {32'd0, mdl_c[idx]};
        else if (op == 1) data = {mdl_c[2], mdl_c[1], mdl_c[0]};
        else              data = {16'd0, mdl_c[9], mdl_c[8]};
      end
      3: begin
        mdl_reload();
        ok = mdl_sig_ok();
      end
      4: begin
        if (idx >= 64) return;
        exp_q.push_back({1'b1, 6'(idx), wd});
        mdl_ee[idx] = wd;
        mdl_c[10] = 16'h0000;
        ok = 1'b1;
      end
      5: begin
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < 63; i++) begin
          exp_q.push_back({1'b0, 6'(i), 16'h0});
          s += mdl_ee[i];
        end
        exp_q.push_back({1'b1, 6'd63, 16'hBABA - s});
        mdl_ee[63] = 16'hBABA - s;
        mdl_c[10] = 16'h0000;
        ok = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic run_cmd(input string req, input int op, input int idx,
                         input logic [15:0] wd, input bit poke);
    logic        eok;
    logic [47:0] edata;
    bit          hit;
    int          n;
    predict(op, idx, wd, eok, edata);
    hit = (exp_q.size() == 0);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_idx   = 7'(idx);
    cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!done) begin
      chk({req, " R11 busy while pending"}, {47'd0, busy}, 48'd1);
      if (poke && n == 5) begin
        cmd_valid = 1'b1;
        cmd_op    = 3'd4;
        cmd_idx   = 7'd3;
        cmd_wdata = 16'hDEAD;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      n++;
      if (n > 20000) break;
    end
    chk({req, " status"}, {47'd0, done_ok}, {47'd0, eok});
    chk({req, " result"}, resp_data, edata);
    chk({req, " R2 all transfers made"}, 48'(exp_q.size()), 48'd0);
    if (hit) chk({req, " R5 done latency"}, 48'(n), 48'd2);
    exp_q.delete();
    @(negedge clk);
    chk({req, " R11 idle after done"}, {46'd0, busy, done}, 48'd0);
  endtask

  initial begin
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 63; i++) begin
      ee[i] = 16'(i * 16'h0707) ^ 16'h2C31;
      if (i == 10) ee[i] = 16'h4A5A;
      s += ee[i];
    end
    ee[63] = 16'hBABA - s;
    for (int i = 0; i < 64; i++) begin
      mdl_ee[i] = ee[i];
      mdl_c[i]  = 16'h0000;
    end
    cmd_valid = 1'b0;
    cmd_op    = '0;
    cmd_idx   = '0;
    cmd_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {45'd0, busy, done, mst_req}, 48'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {45'd0, busy, done, mst_req}, 48'd0);

    run_cmd("R1 R3 first word read reloads", 0, 5, 16'h0, 1'b0);
    run_cmd("R5 cached word", 0, 12, 16'h0, 1'b0);
    run_cmd("R7 station", 1, 0, 16'h0, 1'b0);
    run_cmd("R7 board", 2, 0, 16'h0, 1'b0);
    run_cmd("R6 index 64", 0, 64, 16'h0, 1'b0);
    run_cmd("R6 index 127", 0, 127, 16'h0, 1'b0);
    run_cmd("R8 write index 70 rejected", 4, 70, 16'h5555, 1'b0);
    run_cmd("R8 cache kept after reject", 0, 7, 16'h0, 1'b0);
    run_cmd("R12 opcode 7", 7, 1, 16'h0, 1'b0);
    run_cmd("R12 opcode 6", 6, 1, 16'h0, 1'b0);
    run_cmd("R8 write word 5", 4, 5, 16'h1111, 1'b0);
    run_cmd("R4 R6 read after bad sum", 0, 5, 16'h0, 1'b0);
    run_cmd("R4 reload repeats", 0, 6, 16'h0, 1'b0);
    run_cmd("R9 update", 5, 0, 16'h0, 1'b0);
    run_cmd("R3 board after update", 2, 0, 16'h0, 1'b0);
    run_cmd("R10 R11 forced load with ignored request", 3, 0, 16'h0, 1'b1);
    run_cmd("R11 word 3 untouched", 0, 3, 16'h0, 1'b0);
    run_cmd("R8 write bad signature", 4, 10, 16'h8000, 1'b0);
    run_cmd("R9 update again", 5, 0, 16'h0, 1'b0);
    run_cmd("R3 R10 load bad signature", 3, 0, 16'h0, 1'b0);
    run_cmd("R6 word invalid after reload", 0, 2, 16'h0, 1'b0);
    run_cmd("R8 write good signature", 4, 10, 16'h4321, 1'b0);
    run_cmd("R9 update third", 5, 0, 16'h0, 1'b0);
    run_cmd("R3 R7 station after repair", 1, 0, 16'h0, 1'b0);
    run_cmd("R5 word 10 cached", 0, 10, 16'h0, 1'b0);
    summary();
  end
endmodule